// File: doc/BRIEF.md
# Combinational Non-Restoring Integer Square Root

This block returns the integer part of the square root of an unsigned radicand. It has no clock. Its output is a pure function of its input. The radicand width is a parameter and the root is half that width. In a gradient-magnitude datapath it takes the sum of two squared gradients and returns the magnitude, for example a 60-bit sum giving a 30-bit magnitude.

The design is a chain of identical stages. Each stage takes the next two radicand bits, starting from the most significant pair, and produces one root bit. The partial remainder is kept in two's complement:

- When the incoming remainder is negative, the stage adds the trial term.
- Otherwise, it subtracts the trial term.

This removes the restore step. A small correction unit at the end makes the final remainder non-negative. Only the assertions use that corrected remainder. No multiplier appears in the datapath.

Top module: `nr_isqrt`

## Requirements
- R1: For every radicand `num_i`, `root_o` equals the largest integer r with r*r <= `num_i`.
- R2: A radicand of 0 gives a root of 0.
- R3: A radicand of 1 gives a root of 1.
- R4: The all-ones radicand gives a root whose bits are all one (65535 for the default 32-bit radicand).
- R5: For a perfect square k*k, the root is exactly k.
- R6: For k*k-1 with k >= 1, the root is k-1.
- R7: The block holds no state. The root for a given radicand is the same whatever was applied before, and it follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| num_i | input | IN_W (default 32) | Unsigned radicand; IN_W must be even |
| root_o | output | IN_W/2 | Integer square root, rounded down |

## Verification
Assertions inside the design are evaluated whenever the input changes. At every stage they check the non-restoring invariant: the signed remainder equals the consumed radicand prefix minus the square of the root so far, or minus the square of the root so far plus one when the new bit is 0. At the output they check that the root squared plus the corrected remainder rebuilds the radicand, that the remainder lies between 0 and twice the root, and that the root is bounded from both sides. The bench has to show the rest through its scenarios: the specific corner values (zero, one, all ones, squares and their predecessors), and the absence of memory, which it shows by applying the same radicand after very different histories.

// File: rtl/nr_isqrt_pkg.sv
package nr_isqrt_pkg;

    // Operation applied to the partial remainder at one stage
    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } nr_op_e;

    // Guard bits carried by the signed remainder above the root width
    localparam int unsigned REM_GUARD = 3;

    function automatic bit width_is_even(input int unsigned w);
        return (w % 2) == 0;
    endfunction

    function automatic int unsigned root_width(input int unsigned w);
        return w / 2;
    endfunction

endpackage

// File: rtl/nr_isqrt_stage.sv
module nr_isqrt_stage
    import nr_isqrt_pkg::*;
#(
    parameter int unsigned QW = 16,
    localparam int unsigned RW = QW + REM_GUARD
) (
    input  logic signed [RW-1:0] rem_i,
    input  logic        [QW-1:0] root_i,
    input  logic        [1:0]    pair_i,
    output logic signed [RW-1:0] rem_o,
    output logic        [QW-1:0] root_o
);

    nr_op_e              op;
    logic signed [RW-1:0] shifted;
    logic signed [RW-1:0] trial;
    logic                 new_bit;

    always_comb begin
        op      = rem_i[RW-1] ? OP_ADD : OP_SUB;
        shifted = (rem_i <<< 2) | {{(RW-2){1'b0}}, pair_i};
        // trial term: 4*root + 1 when subtracting, 4*root + 3 when adding
        trial   = (RW'(root_i) <<< 2) | {{(RW-2){1'b0}}, (op == OP_ADD) ? 2'b11 : 2'b01};
        rem_o   = (op == OP_ADD) ? (shifted + trial) : (shifted - trial);
        new_bit = ~rem_o[RW-1];
        root_o  = (root_i << 1) | {{(QW-1){1'b0}}, new_bit};
    end

endmodule

// File: rtl/nr_isqrt_fixup.sv
module nr_isqrt_fixup
    import nr_isqrt_pkg::*;
#(
    parameter int unsigned QW = 16,
    localparam int unsigned RW = QW + REM_GUARD
) (
    input  logic signed [RW-1:0] rem_i,
    input  logic        [QW-1:0] root_i,
    output logic signed [RW-1:0] rem_o
);

    logic signed [RW-1:0] corr;

    always_comb begin
        corr  = (RW'(root_i) <<< 1) | RW'(1);
        rem_o = rem_i[RW-1] ? (rem_i + corr) : rem_i;
    end

    logic signed [RW+1:0] twice_root;
    always_comb begin
        twice_root = (RW+2)'(root_i) <<< 1;
        if (!$isunknown(rem_i) && !$isunknown(root_i)) begin
            // R1
            rem_nonneg_chk: assert (rem_o[RW-1] == 1'b0)
                else $error("corrected remainder is negative");
            // R1
            rem_range_chk: assert ((RW+2)'(rem_o) <= twice_root)
                else $error("corrected remainder exceeds twice the root");
        end
    end

endmodule

// File: rtl/nr_isqrt.sv
module nr_isqrt
    import nr_isqrt_pkg::*;
#(
    parameter int unsigned IN_W = 32,
    localparam int unsigned OUT_W = IN_W / 2,
    localparam int unsigned RW = OUT_W + REM_GUARD
) (
    input  logic [IN_W-1:0]  num_i,
    output logic [OUT_W-1:0] root_o
);

    if (!width_is_even(IN_W) || IN_W < 4) begin : g_bad_width
        $error("nr_isqrt: IN_W must be even and at least 4");
    end

    logic signed [RW-1:0]    rem_chain  [OUT_W+1];
    logic        [OUT_W-1:0] root_chain [OUT_W+1];
    logic signed [RW-1:0]    rem_final;

    assign rem_chain[0]  = '0;
    assign root_chain[0] = '0;

    localparam int unsigned WW = IN_W + 4;

    for (genvar k = 0; k < OUT_W; k++) begin : g_stage
        nr_isqrt_stage #(.QW(OUT_W)) stage_i (
            .rem_i  (rem_chain[k]),
            .root_i (root_chain[k]),
            .pair_i (num_i[IN_W-1-2*k -: 2]),
            .rem_o  (rem_chain[k+1]),
            .root_o (root_chain[k+1])
        );

        logic signed [WW-1:0] prefix_w;
        logic signed [WW-1:0] q_w;
        logic signed [WW-1:0] q1_w;
        logic signed [WW-1:0] expect_w;
        always_comb begin
            prefix_w = WW'(num_i >> (IN_W - 2*(k+1)));
            q_w      = WW'(root_chain[k+1]);
            q1_w     = q_w + WW'(1);
            expect_w = root_chain[k+1][0] ? (prefix_w - q_w*q_w) : (prefix_w - q1_w*q1_w);
            if (!$isunknown(num_i)) begin
                // R1
                stage_invariant_chk: assert (WW'(rem_chain[k+1]) == expect_w)
                    else $error("stage %0d remainder breaks the invariant", k);
            end
        end
    end

    nr_isqrt_fixup #(.QW(OUT_W)) fixup_i (
        .rem_i  (rem_chain[OUT_W]),
        .root_i (root_chain[OUT_W]),
        .rem_o  (rem_final)
    );

    assign root_o = root_chain[OUT_W];

    logic [WW-1:0] r_w;
    logic [WW-1:0] r1_w;
    always_comb begin
        r_w  = WW'(root_o);
        r1_w = r_w + WW'(1);
        if (!$isunknown(num_i)) begin
            // R1
            root_low_chk: assert (r_w*r_w <= WW'(num_i))
                else $error("root squared exceeds radicand");
            // R1
            root_high_chk: assert (r1_w*r1_w > WW'(num_i))
                else $error("root is not the largest fitting value");
            // R1
            rebuild_chk: assert (r_w*r_w + WW'(rem_final) == WW'(num_i))
                else $error("root and remainder do not rebuild the radicand");
        end
    end

endmodule

// File: tb/nr_isqrt_tb.sv
module nr_isqrt_tb_top;

    localparam int unsigned IN_W  = 32;
    localparam int unsigned OUT_W = IN_W / 2;
    localparam int unsigned NVEC  = 14;

    logic             clk = 1'b0;
    logic [IN_W-1:0]  num;
    logic [OUT_W-1:0] root;
    int               checks   = 0;
    int               failures = 0;
    bit               finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nr_isqrt #(.IN_W(IN_W)) dut_i (
        .num_i  (num),
        .root_o (root)
    );

    // radicand / expected root pairs (R1 to R6 corners)
    localparam logic [IN_W-1:0] VEC_IN [NVEC] = '{
        32'd0,          // R2
        32'd1,          // R3
        32'd2, 32'd3,   // R1
        32'd4,          // R5
        32'd15,         // R6
        32'd16,         // R5
        32'd99,         // R6
        32'd100,        // R5
        32'd65535,      // R6
        32'd65536,      // R5
        32'hFFFF_FFFF,  // R4
        32'hFFFE_0001,  // R5
        32'hFFFE_0000   // R6
    };
    localparam logic [OUT_W-1:0] VEC_EXP [NVEC] = '{
        16'd0, 16'd1, 16'd1, 16'd1, 16'd2, 16'd3, 16'd4,
        16'd9, 16'd10, 16'd255, 16'd256, 16'd65535, 16'd65535, 16'd65534
    };

    function automatic logic [OUT_W-1:0] ref_root(input logic [IN_W-1:0] v);
        logic [OUT_W-1:0] r;
        r = '0;
        for (int b = OUT_W-1; b >= 0; b--) begin
            logic [OUT_W-1:0] t;
            t = r | (OUT_W'(1) << b);
            if (longint'(t) * longint'(t) <= longint'(v)) r = t;
        end
        return r;
    endfunction

    task automatic apply_check(input string req, input logic [IN_W-1:0] n,
                               input logic [OUT_W-1:0] exp_r);
        @(negedge clk);
        num = n;
        #1;
        checks++;
        if (root !== exp_r) begin
            failures++;
            $display("FAIL %s num=%0d actual=%0d expected=%0d", req, n, root, exp_r);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        num = '0;
        // initial state with zero radicand: R2
        apply_check("R2", 32'd0, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply_check("R1", VEC_IN[i], VEC_EXP[i]);
        end

        // directed corners
        apply_check("R2", 32'd0, 16'd0);
        apply_check("R3", 32'd1, 16'd1);
        apply_check("R4", 32'hFFFF_FFFF, 16'hFFFF);

        // perfect squares and their predecessors: R5, R6
        for (int k = 1; k < 65536; k += 997) begin
            apply_check("R5", IN_W'(k*k), OUT_W'(k));
            apply_check("R6", IN_W'(k*k - 1), OUT_W'(k - 1));
        end
        apply_check("R5", 32'hFFFE_0001, 16'd65535);
        apply_check("R6", 32'd3, 16'd1);

        // no memory: same radicand after different histories, R7
        apply_check("R7", 32'hFFFF_FFFF, 16'hFFFF);
        apply_check("R7", 32'd0, 16'd0);
        apply_check("R7", 32'd50, 16'd7);
        apply_check("R7", 32'd50, 16'd7);
        apply_check("R7", 32'd1, 16'd1);
        apply_check("R7", 32'd50, 16'd7);

        // pseudo-random sweep against the bench reference, R1
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply_check("R1", lfsr, ref_root(lfsr));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule